// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources. Each source can be a hardware request line or a request raised by software. The block gates every source with a per-source enable mask and steers it to one of two processor outputs: a normal interrupt (`irq_out`) or a fast interrupt (`fiq_out`). Software reaches the block through a simple 32-bit register slave port. The port has one select strobe, a write/read flag and a privilege flag. Read data returns combinationally in the same cycle as the request.

Sixteen programmable vector slots each bind a source number to a handler address. Slot 0 has the highest priority. A read of the current-vector register claims the best qualifying request and returns its handler address. When no slot qualifies, the read returns a default address. A write to the same register retires the service level that was claimed most recently. The in-service levels mask requests of equal and lower priority, so interrupts can nest in strict priority order. A protect bit can restrict all writes to privileged accesses. Four read-only registers return a fixed cell identifier one byte at a time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0, so all sources start disabled, software requests are clear, every source is routed to `irq_out`, and both outputs are low.
- R2: Writing ones at byte offset 0x10 enables those sources, and writing ones at 0x14 disables them. Zero bits in either write leave their sources unchanged. A read of 0x10 returns the enable mask.
- R3: Writing ones at 0x18 raises software requests on those sources, and writing ones at 0x1C drops them. A read of 0x18 returns the software request bits.
- R4: Raw status (read at 0x08) is `src_req` OR the software bits. Normal status (0x00) is raw AND enable AND NOT select. Fast status (0x04) is raw AND enable AND select. `irq_out` and `fiq_out` are the OR of their status words and follow `src_req` in the same cycle.
- R5: In the steering register at 0x0C, bit n = 1 routes source n to the fast output and bit n = 0 routes it to the normal output. The register reads back as written.
- R6: Slot n has a handler address register at 0x100+4n and a control register at 0x200+4n. In the control register, bit 5 enables the slot and bits [4:0] name the source. Both registers read back as written. A disabled slot never matches.
- R7: A read at 0x30 returns the address of the lowest-numbered enabled slot that meets two conditions: its source is set in normal status, and its number is below the slot numbers currently in service. The read marks that slot in service, so a repeat read does not return it again while it remains in service.
- R8: If normal status is nonzero and no slot qualifies, a read at 0x30 returns the default address held at 0x34. The read claims a default service level only when nothing is in service. With normal status zero, the read returns the default address and claims nothing.
- R9: A write of any value at 0x30 retires the highest-priority level in service. With nothing in service, the write has no effect.
- R10: While protect bit 0 (offset 0x20) is set, writes with `bus_priv` low change no register.
- R11: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0, 1, 2 and 3 of `CELL_ID` in bits [7:0], with the upper bits at 0. Vendor code is at `CELL_ID` bits [19:12].
- R12: Bit 0 of the test control register at 0x300 is writable and reads back. The value 0 means normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| src_req | input | NSRC | Hardware request lines, active high |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The two outputs and all three status words are combinational in `src_req`. The bench therefore changes the request lines on a falling edge and samples a quarter period later, in the same cycle. Every register write lands on the rising edge that ends the write cycle. Read data is combinational, so a read issued in the next cycle already sees the new value. A claim or retire at 0x30 changes the service state only at the rising edge that ends the access. Each scenario checks service-state effects with a follow-up read one or more cycles later, never within the access that caused them.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   // word addresses (byte address >> 2)
   localparam logic [9:0] W_IRQ_STAT = 10'h000;
   localparam logic [9:0] W_FIQ_STAT = 10'h001;
   localparam logic [9:0] W_RAW_STAT = 10'h002;
   localparam logic [9:0] W_STEER    = 10'h003;
   localparam logic [9:0] W_EN_SET   = 10'h004;
   localparam logic [9:0] W_EN_CLR   = 10'h005;
   localparam logic [9:0] W_SW_SET   = 10'h006;
   localparam logic [9:0] W_SW_CLR   = 10'h007;
   localparam logic [9:0] W_GUARD    = 10'h008;
   localparam logic [9:0] W_VEC_CUR  = 10'h00C;
   localparam logic [9:0] W_VEC_DEF  = 10'h00D;
   localparam logic [9:0] W_TEST     = 10'h0C0;
   localparam logic [3:0] PG_VADDR   = 4'h1;
   localparam logic [3:0] PG_VCTRL   = 4'h2;
   localparam logic [7:0] PG_IDENT   = 8'hFE;

   localparam int unsigned CTL_W  = 6;
   localparam int unsigned CTL_EN = 5;

   typedef logic [CTL_W-1:0] slot_ctl_t;
endpackage

// File: rtl/ivc_src_gate.sv
module ivc_src_gate #(
   parameter int unsigned NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   input  logic [NSRC-1:0] soft_i,
   input  logic [NSRC-1:0] en_i,
   input  logic [NSRC-1:0] steer_i,
   output logic [NSRC-1:0] raw_o,
   output logic [NSRC-1:0] irq_stat_o,
   output logic [NSRC-1:0] fiq_stat_o,
   output logic            irq_o,
   output logic            fiq_o
);
   assign raw_o      = req_i | soft_i;
   assign irq_stat_o = raw_o & en_i & ~steer_i;
   assign fiq_stat_o = raw_o & en_i & steer_i;
   assign irq_o      = |irq_stat_o;
   assign fiq_o      = |fiq_stat_o;

   // R4
   gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0) |-> (!irq_o && !fiq_o));
   // R5
   all_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (steer_i == '1) |-> !irq_o);
   // R4
   disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat_o & fiq_stat_o) == '0);
endmodule

// File: rtl/ivc_slot_arb.sv
module ivc_slot_arb
   import ivc_pkg::*;
#(
   parameter int unsigned NSRC  = 32,
   parameter int unsigned NSLOT = 16,
   parameter int unsigned IW    = 4,
   parameter int unsigned LW    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  slot_ctl_t [NSLOT-1:0] ctl_i,
   input  logic [NSRC-1:0]       irq_stat_i,
   input  logic [LW-1:0]         top_lvl_i,
   output logic                  hit_o,
   output logic [IW-1:0]         hit_idx_o
);
   logic [31:0]      stat32;
   logic [NSLOT-1:0] cand;

   assign stat32 = 32'(irq_stat_i);

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      assign cand[g] = ctl_i[g][CTL_EN] && stat32[ctl_i[g][4:0]]
                       && (LW'(g) < top_lvl_i);
   end

   always_comb begin
      hit_o     = 1'b0;
      hit_idx_o = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (cand[i]) begin
            hit_o     = 1'b1;
            hit_idx_o = IW'(i);
         end
      end
   end

   // R6
   hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ctl_i[hit_idx_o][CTL_EN]);
   // R7
   hit_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> stat32[ctl_i[hit_idx_o][4:0]]);
endmodule

// File: rtl/ivc_svc_stack.sv
module ivc_svc_stack #(
   parameter int unsigned NSLOT = 16,
   parameter int unsigned LW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [LW-1:0] push_lvl_i,
   input  logic          pop_i,
   output logic [LW-1:0] top_lvl_o,
   output logic          empty_o
);
   localparam int unsigned NLVL = NSLOT + 1;

   logic [NLVL-1:0] busy_q;

   always_comb begin
      top_lvl_o = LW'(NLVL);
      for (int i = NLVL - 1; i >= 0; i--) begin
         if (busy_q[i]) top_lvl_o = LW'(i);
      end
   end

   assign empty_o = (busy_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else if (pop_i) begin
         busy_q <= busy_q & (busy_q - NLVL'(1));
      end else if (push_i) begin
         busy_q[push_lvl_i] <= 1'b1;
      end
   end

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> empty_o);
   // R7
   push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (push_lvl_i < top_lvl_o));
   // R7
   push_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> (top_lvl_o == $past(push_lvl_i)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned NSLOT       = 16,
   parameter int unsigned VW          = 32,
   parameter logic [31:0] CELL_ID     = 32'h00B4_7E19,
   parameter bit          HAS_PROTECT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_write,
   input  logic            bus_priv,
   input  logic [11:0]     bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   input  logic [NSRC-1:0] src_req,
   output logic            irq_out,
   output logic            fiq_out
);
   localparam int unsigned IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int unsigned LW = $clog2(NSLOT + 2);

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("NSRC must lie in 1..32");
   end
   if (NSLOT < 1 || NSLOT > 32) begin : g_bad_nslot
      $error("NSLOT must lie in 1..32");
   end
   if (VW < 1 || VW > 32) begin : g_bad_vw
      $error("VW must lie in 1..32");
   end

   logic [NSRC-1:0]       en_q, soft_q, steer_q;
   logic                  prot_q, test_q;
   logic [VW-1:0]         dflt_q;
   slot_ctl_t [NSLOT-1:0] vctl_q;
   logic [NSLOT-1:0][VW-1:0] vadr_q;

   logic [NSRC-1:0] raw, irq_stat, fiq_stat;
   logic            hit;
   logic [IW-1:0]   hit_idx;
   logic [LW-1:0]   top_lvl;
   logic            svc_empty;

   logic [9:0] word;
   logic       wr_ok, rd_go, in_vadr, in_vctl, claim, retire;
   logic [LW-1:0] claim_lvl;
   logic [VW-1:0] cur_vec;

   assign word    = bus_addr[11:2];
   assign wr_ok   = bus_sel && bus_write && (bus_priv || !prot_q);
   assign rd_go   = bus_sel && !bus_write;
   assign in_vadr = (word[9:6] == PG_VADDR) && (int'(word[5:0]) < NSLOT);
   assign in_vctl = (word[9:6] == PG_VCTRL) && (int'(word[5:0]) < NSLOT);

   ivc_src_gate #(.NSRC(NSRC)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .req_i(src_req), .soft_i(soft_q), .en_i(en_q), .steer_i(steer_q),
      .raw_o(raw), .irq_stat_o(irq_stat), .fiq_stat_o(fiq_stat),
      .irq_o(irq_out), .fiq_o(fiq_out)
   );

   ivc_slot_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .IW(IW), .LW(LW)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .ctl_i(vctl_q), .irq_stat_i(irq_stat), .top_lvl_i(top_lvl),
      .hit_o(hit), .hit_idx_o(hit_idx)
   );

   assign cur_vec   = hit ? vadr_q[hit_idx] : dflt_q;
   assign claim_lvl = hit ? LW'(hit_idx) : LW'(NSLOT);
   assign claim     = rd_go && (word == W_VEC_CUR) && (hit || (irq_out && svc_empty));
   assign retire    = wr_ok && (word == W_VEC_CUR);

   ivc_svc_stack #(.NSLOT(NSLOT), .LW(LW)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push_i(claim), .push_lvl_i(claim_lvl), .pop_i(retire),
      .top_lvl_o(top_lvl), .empty_o(svc_empty)
   );

   if (HAS_PROTECT) begin : g_prot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            prot_q <= 1'b0;
         else if (wr_ok && word == W_GUARD)     prot_q <= bus_wdata[0];
      end
   end else begin : g_noprot
      assign prot_q = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         soft_q  <= '0;
         steer_q <= '0;
         test_q  <= 1'b0;
         dflt_q  <= '0;
         vctl_q  <= '0;
         vadr_q  <= '0;
      end else if (wr_ok) begin
         case (word)
            W_STEER:   steer_q <= bus_wdata[NSRC-1:0];
            W_EN_SET:  en_q    <= en_q | bus_wdata[NSRC-1:0];
            W_EN_CLR:  en_q    <= en_q & ~bus_wdata[NSRC-1:0];
            W_SW_SET:  soft_q  <= soft_q | bus_wdata[NSRC-1:0];
            W_SW_CLR:  soft_q  <= soft_q & ~bus_wdata[NSRC-1:0];
            W_VEC_DEF: dflt_q  <= bus_wdata[VW-1:0];
            W_TEST:    test_q  <= bus_wdata[0];
            default: begin
               if (in_vadr) vadr_q[word[IW-1:0]] <= bus_wdata[VW-1:0];
               if (in_vctl) vctl_q[word[IW-1:0]] <= bus_wdata[CTL_W-1:0];
            end
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_go) begin
         case (word)
            W_IRQ_STAT: bus_rdata = 32'(irq_stat);
            W_FIQ_STAT: bus_rdata = 32'(fiq_stat);
            W_RAW_STAT: bus_rdata = 32'(raw);
            W_STEER:    bus_rdata = 32'(steer_q);
            W_EN_SET:   bus_rdata = 32'(en_q);
            W_SW_SET:   bus_rdata = 32'(soft_q);
            W_GUARD:    bus_rdata = 32'(prot_q);
            W_VEC_CUR:  bus_rdata = 32'(cur_vec);
            W_VEC_DEF:  bus_rdata = 32'(dflt_q);
            W_TEST:     bus_rdata = 32'(test_q);
            default: begin
               if (in_vadr)
                  bus_rdata = 32'(vadr_q[word[IW-1:0]]);
               else if (in_vctl)
                  bus_rdata = 32'(vctl_q[word[IW-1:0]]);
               else if (word[9:2] == PG_IDENT)
                  bus_rdata = {24'b0, CELL_ID[8*word[1:0] +: 8]};
            end
         endcase
      end
   end

   // R10
   guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_write && !bus_priv && prot_q)
      |=> ($stable(en_q) && $stable(soft_q) && $stable(steer_q) && $stable(prot_q)));
   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && word == W_EN_SET)
      |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
   // R2
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && word == W_EN_CLR)
      |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
   // R8
   no_req_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && word == W_VEC_CUR && !irq_out) |-> !claim);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_write = 1'b0, bus_priv = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src_req = '0;
   logic        irq_out, fiq_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_write(bus_write), .bus_priv(bus_priv),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_req(src_req), .irq_out(irq_out), .fiq_out(fiq_out)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic priv = 1'b1);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b1; bus_priv = priv;
      bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #(CLK_P/4) d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic set_req(input logic [31:0] r);
      @(negedge clk);
      src_req = r;
      #(CLK_P/4);
   endtask

   task automatic clean();
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h01C, 32'hFFFF_FFFF);
      wr(12'h00C, 32'h0);
      set_req(32'h0);
   endtask

   task automatic t_reset();
      chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
      chk("R1 fiq_out", {31'b0, fiq_out}, 32'h0);
      rd_chk("R1 irq stat", 12'h000, 32'h0);
      rd_chk("R1 fiq stat", 12'h004, 32'h0);
      rd_chk("R1 raw", 12'h008, 32'h0);
      rd_chk("R1 steer", 12'h00C, 32'h0);
      rd_chk("R1 enable", 12'h010, 32'h0);
      rd_chk("R1 soft", 12'h018, 32'h0);
      rd_chk("R1 protect", 12'h020, 32'h0);
      rd_chk("R1 default vec", 12'h034, 32'h0);
      rd_chk("R1 slot addr", 12'h100, 32'h0);
      rd_chk("R1 slot ctl", 12'h23C, 32'h0);
      rd_chk("R1 test ctl", 12'h300, 32'h0);
   endtask

   task automatic t_enable();
      wr(12'h010, 32'h0000_00F0);
      rd_chk("R2 set", 12'h010, 32'h0000_00F0);
      wr(12'h014, 32'h0000_0030);
      rd_chk("R2 clear", 12'h010, 32'h0000_00C0);
      wr(12'h010, 32'h0);
      rd_chk("R2 zero set no effect", 12'h010, 32'h0000_00C0);
      wr(12'h014, 32'h0);
      rd_chk("R2 zero clear no effect", 12'h010, 32'h0000_00C0);
      wr(12'h010, 32'h8000_0000);
      rd_chk("R2 top bit", 12'h010, 32'h8000_00C0);
      clean();
   endtask

   task automatic t_soft();
      wr(12'h018, 32'h0000_0005);
      rd_chk("R3 soft set", 12'h018, 32'h0000_0005);
      set_req(32'h0001_0000);
      rd_chk("R4 raw merge", 12'h008, 32'h0001_0005);
      wr(12'h01C, 32'h0000_0004);
      rd_chk("R3 soft clear", 12'h018, 32'h0000_0001);
      wr(12'h018, 32'h0);
      rd_chk("R3 zero no effect", 12'h018, 32'h0000_0001);
      clean();
   endtask

   task automatic t_steer();
      wr(12'h018, 32'h0000_0001);
      wr(12'h010, 32'h0000_003D);
      wr(12'h00C, 32'h0000_0028);
      rd_chk("R5 steer readback", 12'h00C, 32'h0000_0028);
      set_req(32'h0000_00F0);
      rd_chk("R4 raw", 12'h008, 32'h0000_00F1);
      rd_chk("R4 irq stat", 12'h000, 32'h0000_0011);
      rd_chk("R5 fiq stat", 12'h004, 32'h0000_0020);
      chk("R4 irq_out high", {31'b0, irq_out}, 32'h1);
      chk("R5 fiq_out high", {31'b0, fiq_out}, 32'h1);
      set_req(32'h0000_0020);
      wr(12'h01C, 32'h1);
      chk("R4 irq_out follows", {31'b0, irq_out}, 32'h0);
      chk("R5 fiq_out stays", {31'b0, fiq_out}, 32'h1);
      wr(12'h014, 32'h0000_003D);
      chk("R4 fiq_out gated", {31'b0, fiq_out}, 32'h0);
      clean();
   endtask

   task automatic t_vector();
      wr(12'h200, 32'h23);  wr(12'h100, 32'h0000_A000);
      wr(12'h204, 32'h27);  wr(12'h104, 32'h0000_A100);
      wr(12'h208, 32'h09);  wr(12'h108, 32'h0000_A200);
      wr(12'h034, 32'h0000_DEF0);
      wr(12'h010, 32'h0000_0288);
      rd_chk("R6 ctl readback", 12'h208, 32'h09);
      rd_chk("R6 addr readback", 12'h104, 32'h0000_A100);
      set_req(32'h0000_0080);
      rd_chk("R7 claim slot1", 12'h030, 32'h0000_A100);
      rd_chk("R7 equal masked", 12'h030, 32'h0000_DEF0);
      set_req(32'h0000_0088);
      rd_chk("R7 nest slot0", 12'h030, 32'h0000_A000);
      rd_chk("R8 default no claim", 12'h030, 32'h0000_DEF0);
      wr(12'h030, 32'h0);
      rd_chk("R9 retire slot0", 12'h030, 32'h0000_A000);
      wr(12'h030, 32'h0);
      wr(12'h030, 32'h0);
      wr(12'h030, 32'h0);
      set_req(32'h0000_0080);
      rd_chk("R9 empty retire ignored", 12'h030, 32'h0000_A100);
      wr(12'h030, 32'h0);
      set_req(32'h0000_0200);
      rd_chk("R6 disabled slot -> default", 12'h030, 32'h0000_DEF0);
      set_req(32'h0000_0208);
      rd_chk("R8 default claim masks only default", 12'h030, 32'h0000_A000);
      wr(12'h030, 32'h0);
      wr(12'h030, 32'h0);
      set_req(32'h0);
      rd_chk("R8 idle read", 12'h030, 32'h0000_DEF0);
      set_req(32'h0000_0080);
      rd_chk("R8 idle read claimed nothing", 12'h030, 32'h0000_A100);
      wr(12'h030, 32'h0);
      clean();
   endtask

   task automatic t_protect();
      wr(12'h020, 32'h1, 1'b1);
      rd_chk("R10 protect set", 12'h020, 32'h1);
      wr(12'h010, 32'h0000_00FF, 1'b0);
      rd_chk("R10 user write dropped", 12'h010, 32'h0);
      wr(12'h020, 32'h0, 1'b0);
      rd_chk("R10 protect kept", 12'h020, 32'h1);
      wr(12'h010, 32'h0000_0003, 1'b1);
      rd_chk("R10 priv write", 12'h010, 32'h0000_0003);
      wr(12'h020, 32'h0, 1'b1);
      wr(12'h014, 32'h0000_0003, 1'b0);
      rd_chk("R10 unprotected user write", 12'h010, 32'h0);
   endtask

   task automatic t_ident();
      rd_chk("R11 id byte0", 12'hFE0, 32'h0000_0019);
      rd_chk("R11 id byte1", 12'hFE4, 32'h0000_007E);
      rd_chk("R11 id byte2", 12'hFE8, 32'h0000_00B4);
      rd_chk("R11 id byte3", 12'hFEC, 32'h0000_0000);
   endtask

   task automatic t_test_ctl();
      wr(12'h300, 32'h1);
      rd_chk("R12 test set", 12'h300, 32'h1);
      wr(12'h300, 32'h0);
      rd_chk("R12 test normal", 12'h300, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #(CLK_P/4);
      t_reset();
      t_enable();
      t_soft();
      t_steer();
      t_vector();
      t_protect();
      t_ident();
      t_test_ctl();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule